// File: doc/BRIEF.md
# Iterative Restoring Integer Divider

This block divides one unsigned N-bit integer by another and returns both the quotient and the remainder. It takes one clock per quotient bit. A one-cycle `start` pulse, sent while the block is idle, captures the dividend and divisor. The block then works through N steps on a working register. That register joins a partial remainder to a shifted quotient. Each step finds one more quotient bit, with the most significant bit coming first. After the last step `done` pulses for one cycle. The results stay on `quotient` and `remainder` until the next accepted start.

Each step shifts the remainder:quotient pair left by one bit. It then tries to subtract the divisor from the partial remainder. One ripple adder does both the size comparison and the subtraction. Its inputs are the partial remainder, the inverted divisor and a carry-in of one, and its carry-out decides whether the divisor fits. The divisor is inverted only once, when the operands are captured, and that inverted copy is used on every step. The partial remainder has one bit more than the operands, so no bit is lost when the divisor's top bit is set. A zero divisor needs no special path: the operation still takes N steps and leaves an all-ones quotient and a remainder equal to the dividend.

Top module: `restore_divider`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` seen on a clock edge while `busy` is 0 captures `dividend` and `divisor`, and `busy` is 1 after that edge.
- R3: `busy` stays 1 for exactly N cycles after the capture edge. On the edge where it falls, `done` rises, and `done` is high for one cycle only.
- R4: When `done` is 1 and the captured divisor is nonzero, `quotient` equals dividend / divisor and `remainder` equals dividend % divisor.
- R5: With a zero divisor the operation still takes N cycles. At `done`, `quotient` is all ones and `remainder` equals the dividend.
- R6: A `start` while `busy` is 1 is ignored. The running operation keeps its timing and its result.
- R7: After `done`, `quotient` and `remainder` keep their values until the next accepted start. Changes on `dividend` and `divisor` without `start` have no effect on them.
- R8: Quotient bits come out most significant first. After k of the N steps (0 < k < N), `remainder` equals P % divisor and `quotient[k-1:0]` equals P / divisor, where P is the dividend shifted right by N-k.
- R9: The results are exact for divisors whose top bit is set and for dividends up to 2^N-1.
- R10: A `start` given in the same cycle that `done` is high is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to capture operands and begin a division |
| dividend | input | N | Unsigned dividend, sampled when a start is accepted |
| divisor | input | N | Unsigned divisor, sampled when a start is accepted |
| busy | output | 1 | High while division steps are running |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | N | Quotient; shows partial progress while busy |
| remainder | output | N | Remainder; shows the partial remainder while busy |

## Verification
The bench builds the divider with N = 8, so each step's adder is 9 bits wide. At this width the extreme operands are easy to reach: all-ones dividends, divisors at and above 128, a divisor of one and a divisor of zero. Every operation is compared with the language's own `/` and `%` operators, both for a fixed table of corner pairs and for several hundred random pairs. Because the result ports show progress while the block is busy, N = 8 also lets the bench check the partial remainder and the partial quotient after every single step of every operation.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

endpackage

// File: rtl/rdiv_adder.sv
// Ripple-carry adder shared by the fit test and the subtraction.
module rdiv_adder #(
    parameter int W = 9
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]       = x[i] ^ y[i] ^ carry[i];
        assign carry[i + 1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end

    assign cout = carry[W];

endmodule

// File: rtl/rdiv_step.sv
// One restoring step: shift the rem:quo pair left, try to subtract the divisor.
module rdiv_step #(
    parameter int N = 8
) (
    input  logic [N:0]   rem_in,
    input  logic [N-1:0] quo_in,
    input  logic [N:0]   dinv,      // {1'b1, ~divisor}
    output logic [N:0]   rem_out,
    output logic [N-1:0] quo_out,
    output logic         fits
);

    logic [N:0]   rem_sh;
    logic [N-1:0] quo_sh;
    logic [N:0]   diff;

    // The top bit of rem_in is always clear, so it can be dropped by the shift.
    assign rem_sh = {rem_in[N-1:0], quo_in[N-1]};
    assign quo_sh = {quo_in[N-2:0], 1'b0};

    // rem_sh + (~d) + 1: carry out is set exactly when rem_sh >= d.
    rdiv_adder #(.W(N + 1)) u_add (
        .x    (rem_sh),
        .y    (dinv),
        .cin  (1'b1),
        .sum  (diff),
        .cout (fits)
    );

    assign rem_out = fits ? diff : rem_sh;
    assign quo_out = {quo_sh[N-1:1], fits};

endmodule

// File: rtl/rdiv_ctrl.sv
// Load / iterate / done sequencing.
module rdiv_ctrl #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);
    import rdiv_pkg::*;

    localparam int CW = (N > 2) ? $clog2(N) : 1;

    typedef struct packed {
        run_state_e    st;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load       = 1'b0;
        step       = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    load      = 1'b1;
                    ctl_d.st  = ST_RUN;
                    ctl_d.cnt = CW'(N - 1);
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (ctl_q.cnt == '0) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.cnt  <= '0;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = (ctl_q.st == ST_RUN);
    assign done = ctl_q.done;

    // R3: done lasts a single cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: busy only drops together with done
    a_r3_busy_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R6: a start while running does not restart the sequence
    a_r6_no_reload: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load);

endmodule

// File: rtl/restore_divider.sv
module restore_divider #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder
);

    typedef struct packed {
        logic [N:0]   rem;
        logic [N-1:0] quo;
        logic [N:0]   dinv;
    } dp_s;

    dp_s dp_d, dp_q;

    logic         load, step;
    logic [N:0]   rem_nx;
    logic [N-1:0] quo_nx;
    logic         fits;

    rdiv_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    rdiv_step #(.N(N)) u_step (
        .rem_in  (dp_q.rem),
        .quo_in  (dp_q.quo),
        .dinv    (dp_q.dinv),
        .rem_out (rem_nx),
        .quo_out (quo_nx),
        .fits    (fits)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.rem  = '0;
            dp_d.quo  = dividend;
            dp_d.dinv = {1'b1, ~divisor};
        end else if (step) begin
            dp_d.rem = rem_nx;
            dp_d.quo = quo_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q.rem  <= '0;
            dp_q.quo  <= '0;
            dp_q.dinv <= '1;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign quotient  = dp_q.quo;
    assign remainder = dp_q.rem[N-1:0];

    // ---------------- checks ----------------
    logic [N-1:0] dcap;
    assign dcap = ~dp_q.dinv[N-1:0];

    // Count the cycles spent busy since the last load.
    logic [31:0] run_len_q;
    always_ff @(posedge clk) begin
        if (rst || load) run_len_q <= '0;
        else if (busy)   run_len_q <= run_len_q + 1;
    end

    // R3: exactly N steps between capture and done
    a_r3_run_length: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_len_q == 32'(N)));

    // R4: the adder carry agrees with a direct magnitude compare
    a_r4_fit_decision: assert property (@(posedge clk) disable iff (rst)
        busy |-> (fits == ({dp_q.rem[N-1:0], dp_q.quo[N-1]} >= {1'b0, dcap})));

    // R4: the final remainder is below a nonzero divisor
    a_r4_rem_below_div: assert property (@(posedge clk) disable iff (rst)
        (done && dcap != '0) |-> (remainder < dcap));

    // R5: a zero divisor gives an all-ones quotient
    a_r5_zero_div: assert property (@(posedge clk) disable iff (rst)
        (done && dcap == '0) |-> (quotient == '1));

    // R9: the extra remainder bit is clear between steps
    a_r9_rem_top_clear: assert property (@(posedge clk) disable iff (rst)
        !dp_q.rem[N]);

    // R7: outputs hold while idle with no accepted start
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: tb/sim_restore_divider.sv
module sim_restore_divider;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] dividend, divisor;
    logic         busy, done;
    logic [W-1:0] quotient, remainder;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    restore_divider #(.N(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder)
    );

    // {dividend, divisor}
    localparam logic [15:0] VEC [12] = '{
        {8'd100, 8'd7},   {8'd255, 8'd1},   {8'd255, 8'd255}, {8'd0,   8'd5},
        {8'd254, 8'd255}, {8'd200, 8'd128}, {8'd255, 8'd128}, {8'd7,   8'd9},
        {8'd128, 8'd3},   {8'd1,   8'd1},   {8'd255, 8'd17},  {8'd170, 8'd85}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; starts now and returns at the negedge where done is seen.
    task automatic run_op(input int a, input int b, input bit poke_busy_start);
        int pre;
        dividend = W'(a);
        divisor  = W'(b);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after capture", busy, 1);
        chk("R2 done low after capture", done, 0);
        for (int k = 1; k < W; k++) begin
            @(negedge clk);
            pre = a >> (W - k);
            if (b != 0) begin
                chk("R8 partial remainder", remainder, pre % b);
                chk("R8 partial quotient", quotient & ((1 << k) - 1), pre / b);
            end
            chk("R3 busy during steps", busy, 1);
            chk("R3 no early done", done, 0);
            if (poke_busy_start && k == 3) begin
                dividend = 8'd3;
                divisor  = 8'd2;
                start    = 1'b1;   // R6: must be ignored
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk("R3 done after N steps", done, 1);
        chk("R3 busy falls with done", busy, 0);
        if (b != 0) begin
            chk("R4 quotient", quotient, a / b);
            chk("R4 remainder", remainder, a % b);
        end else begin
            chk("R5 zero-div quotient", quotient, 255);
            chk("R5 zero-div remainder", remainder, a);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int qa, ra;
        rst = 1'b1;
        start = 1'b0;
        dividend = '0;
        divisor = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 quotient", quotient, 0);
        chk("R1 remainder", remainder, 0);

        // R4 / R9 table walk
        for (int i = 0; i < 12; i++) begin
            run_op(int'(VEC[i][15:8]), int'(VEC[i][7:0]), 1'b0);
            @(negedge clk);
        end

        // R9 large divisor, max dividend
        run_op(255, 255, 1'b0);
        @(negedge clk);
        run_op(255, 129, 1'b0);
        @(negedge clk);

        // R5 zero divisor
        run_op(173, 0, 1'b0);
        @(negedge clk);
        run_op(0, 0, 1'b0);
        @(negedge clk);

        // R6 start while busy is ignored
        run_op(219, 13, 1'b1);
        chk("R6 no restart", busy, 0);
        @(negedge clk);

        // R7 hold after done, input changes without start
        run_op(250, 7, 1'b0);
        qa = quotient;
        ra = remainder;
        dividend = 8'd1;
        divisor  = 8'd1;
        repeat (4) @(negedge clk);
        chk("R7 quotient held", quotient, qa);
        chk("R7 remainder held", remainder, ra);
        chk("R7 stays idle", busy, 0);

        // R10 back-to-back: start in the done cycle
        run_op(90, 4, 1'b0);
        run_op(201, 10, 1'b0);
        run_op(33, 200, 1'b0);
        @(negedge clk);

        // random operands
        for (int i = 0; i < 300; i++) begin
            run_op(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), 1'b0);
            @(negedge clk);
        end

        // R1 reset again mid-operation
        dividend = 8'd77;
        divisor  = 8'd5;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after reset", busy, 0);
        chk("R1 quotient after reset", quotient, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule